// File: doc/BRIEF.md
# Sleep Control Register

This block is the 16-bit control register of a power management unit. Software uses it to start sleep transitions, and platform logic uses it to enable the system control interrupt. A write is a single full-width access carrying a little-endian 16-bit value. The register stores the written value, except for a sleep-enable bit that is never stored.

When a write has the sleep-enable bit set, the block decodes a 3-bit sleep-type field taken from the same write. It then raises one of three request outputs for exactly one cycle:
- power off;
- suspend to RAM;
- suspend to disk.

The sleep-type code that selects suspend-to-disk is a configuration input, not a fixed value.

Two sideband inputs force the interrupt-enable bit on or off, independently of software writes. The platform logic connected to the request outputs carries out the actual transition.

Top module: `sleep_ctl`

## Requirements
- R1: While reset is asserted and after it is released, the read value is 0x0000 and no request output is high.
- R2: A write stores the written value with bit 13 (sleep enable) forced to 0. Bit 13 of the read value is therefore always 0, and the other bits read back the written value from the cycle after the write.
- R3: A write with bit 13 set and sleep type (bits 12:10) equal to 0 pulses `req_off` in the cycle after the write.
- R4: A write with bit 13 set and sleep type equal to 1 pulses `req_ram` in the cycle after the write.
- R5: A write with bit 13 set and a sleep type of 2 to 7 that equals `disk_type` pulses `req_disk` in the cycle after the write.
- R6: A write with bit 13 set and a sleep type of 2 to 7 that differs from `disk_type` raises no request, but its value is still stored.
- R7: A write with bit 13 clear raises no request, whatever the sleep type.
- R8: Each request lasts one cycle. At most one request output is high at a time.
- R9: `sci_set` forces bit 0 (interrupt enable) to 1 and `sci_clr` forces it to 0. When both are asserted, `sci_set` wins.
- R10: A sideband input in the same cycle as a write decides bit 0. The written value supplies all other bits.
- R11: A `disk_type` of 0 or 1 redirects nothing: sleep type 0 still requests power off and sleep type 1 still requests suspend to RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 16 | Write value: bit 0 interrupt enable, bits 12:10 sleep type, bit 13 sleep enable |
| disk_type | input | 3 | Sleep-type code that selects suspend to disk |
| sci_set | input | 1 | Force interrupt enable to 1 |
| sci_clr | input | 1 | Force interrupt enable to 0 |
| rd_data | output | 16 | Current register value |
| req_off | output | 1 | One-cycle power-off request |
| req_ram | output | 1 | One-cycle suspend-to-RAM request |
| req_disk | output | 1 | One-cycle suspend-to-disk request |

## Verification
A software write and a sideband force can land in the same cycle, and both target bit 0. The bench provokes this by holding `sci_set` or `sci_clr` in the cycle of a write whose bit 0 has the opposite value. It judges the result by reading back the sideband value in bit 0 and the written value in all other bits.

A second overlap is a sleep request issued back to back with another write. Here the bench checks that each write produces its own single pulse, and that no pulse stretches into a cycle with no cause.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;
  localparam int TYPE_W = 3;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_OFF  = 2'd1,
    KIND_RAM  = 2'd2,
    KIND_DISK = 2'd3
  } slp_kind_e;

  // Sleep-type decode: codes 0 and 1 are fixed, the disk code is configured.
  function automatic slp_kind_e classify(input logic [TYPE_W-1:0] typ,
                                         input logic [TYPE_W-1:0] disk);
    slp_kind_e k;
    if (typ == '0)                  k = KIND_OFF;
    else if (typ == TYPE_W'(1))     k = KIND_RAM;
    else if (typ == disk)           k = KIND_DISK;
    else                            k = KIND_NONE;
    return k;
  endfunction
endpackage

// File: rtl/slpctl_reg.sv
module slpctl_reg #(
  parameter int W       = 16,
  parameter int SLP_BIT = 13,
  parameter int SCI_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         sci_set,
  input  logic         sci_clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] SLP_MASK = W'(1) << SLP_BIT;
  localparam logic [W-1:0] SCI_MASK = W'(1) << SCI_BIT;

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = wr_data & ~SLP_MASK;
    if (sci_set)      nxt[SCI_BIT] = 1'b1;
    else if (sci_clr) nxt[SCI_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !sci_set && !sci_clr |=> q == ($past(wr_data) & ~SLP_MASK));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sci_set |=> q[SCI_BIT]);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sci_clr && !sci_set |=> !q[SCI_BIT]);
  p_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (sci_set || sci_clr) |=>
      (q & ~SCI_MASK) == ($past(wr_data) & ~SLP_MASK & ~SCI_MASK));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !sci_set && !sci_clr |=> $stable(q));
endmodule

// File: rtl/slpctl_decode.sv
module slpctl_decode
  import slpctl_pkg::*;
#(
  parameter int W        = 16,
  parameter int SLP_BIT  = 13,
  parameter int TYPE_LSB = 10
) (
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic [TYPE_W-1:0] disk_type,
  output logic              go_off,
  output logic              go_ram,
  output logic              go_disk
);
  logic              arm;
  logic [TYPE_W-1:0] typ;
  slp_kind_e         kind;

  assign arm  = wr_en && wr_data[SLP_BIT];
  assign typ  = wr_data[TYPE_LSB +: TYPE_W];
  assign kind = classify(typ, disk_type);

  assign go_off  = arm && (kind == KIND_OFF);
  assign go_ram  = arm && (kind == KIND_RAM);
  assign go_disk = arm && (kind == KIND_DISK);
endmodule

// File: rtl/slpctl_pulse.sv
module slpctl_pulse #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] go,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_req
    always_ff @(posedge clk) begin
      if (!rst_n) req[i] <= 1'b0;
      else        req[i] <= go[i];
    end
  end

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req));
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl #(
  parameter int W        = 16,
  parameter int SLP_BIT  = 13,
  parameter int SCI_BIT  = 0,
  parameter int TYPE_LSB = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic [slpctl_pkg::TYPE_W-1:0] disk_type,
  input  logic                         sci_set,
  input  logic                         sci_clr,
  output logic [W-1:0]                 rd_data,
  output logic                         req_off,
  output logic                         req_ram,
  output logic                         req_disk
);
  import slpctl_pkg::*;

  localparam int NREQ = 3;

  logic            go_off, go_ram, go_disk;
  logic [NREQ-1:0] req_vec;
  logic            slp_write;

  assign slp_write = wr_en && wr_data[SLP_BIT];

  slpctl_reg #(.W(W), .SLP_BIT(SLP_BIT), .SCI_BIT(SCI_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sci_set(sci_set), .sci_clr(sci_clr), .q(rd_data)
  );

  slpctl_decode #(.W(W), .SLP_BIT(SLP_BIT), .TYPE_LSB(TYPE_LSB)) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .disk_type(disk_type),
    .go_off(go_off), .go_ram(go_ram), .go_disk(go_disk)
  );

  slpctl_pulse #(.N(NREQ)) u_pulse (
    .clk(clk), .rst_n(rst_n), .go({go_disk, go_ram, go_off}), .req(req_vec)
  );

  assign req_off  = req_vec[0];
  assign req_ram  = req_vec[1];
  assign req_disk = req_vec[2];

  p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_off || req_ram || req_disk) |-> $past(slp_write));
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_off || req_ram || req_disk) && !slp_write
      |=> !(req_off || req_ram || req_disk));
  p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slp_write && wr_data[TYPE_LSB +: TYPE_W] == '0 |=> req_off);
  p_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slp_write && wr_data[TYPE_LSB +: TYPE_W] == TYPE_W'(1) |=> req_ram);
  p_disk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_disk |-> $past(wr_data[TYPE_LSB +: TYPE_W] == disk_type)
                 && $past(wr_data[TYPE_LSB +: TYPE_W] > TYPE_W'(1)));
  p_rdzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[SLP_BIT]);
endmodule

// File: tb/sleep_ctl_tb.sv
module sleep_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  disk_type = 3'd5;
  logic        sci_set = 1'b0;
  logic        sci_clr = 1'b0;
  logic [15:0] rd_data;
  logic        req_off, req_ram, req_disk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sleep_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .disk_type(disk_type), .sci_set(sci_set), .sci_clr(sci_clr),
    .rd_data(rd_data), .req_off(req_off), .req_ram(req_ram), .req_disk(req_disk)
  );

  // request vector as {disk, ram, off}
  function automatic logic [15:0] reqs();
    return {13'b0, req_disk, req_ram, req_off};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // write at a negedge, return one time unit after the capturing edge
  task automatic wr(input logic [15:0] d, input logic s = 1'b0, input logic c = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; sci_set = s; sci_clr = c;
    @(posedge clk); #1;
    wr_en = 1'b0; sci_set = 1'b0; sci_clr = 1'b0;
  endtask

  task automatic idle_cycle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R1 reset read", rd_data, 16'h0000);
    check("R1 reset reqs", reqs(), 16'h0000);
  endtask

  task automatic t_store();
    wr(16'h2C81);
    check("R2 store clears bit13", rd_data, 16'h0C81);
    idle_cycle();
    check("R2 value held", rd_data, 16'h0C81);
    wr(16'hFFFF);
    check("R2 all ones", rd_data, 16'hDFFF);
  endtask

  task automatic t_off();
    disk_type = 3'd5;
    wr(16'h2000);
    check("R3 off pulse", reqs(), 16'h0001);
    check("R3 stored", rd_data, 16'h0000);
    idle_cycle();
    check("R8 off pulse ends", reqs(), 16'h0000);
  endtask

  task automatic t_ram();
    wr(16'h2401);
    check("R4 ram pulse", reqs(), 16'h0002);
    idle_cycle();
    check("R8 ram pulse ends", reqs(), 16'h0000);
  endtask

  task automatic t_disk();
    disk_type = 3'd5;
    wr(16'h3400);
    check("R5 disk pulse", reqs(), 16'h0004);
    check("R5 stored", rd_data, 16'h1400);
    idle_cycle();
    check("R8 disk pulse ends", reqs(), 16'h0000);
    disk_type = 3'd7;
    wr(16'h3C00);
    check("R5 disk code 7", reqs(), 16'h0004);
  endtask

  task automatic t_other();
    disk_type = 3'd5;
    wr(16'h3800);
    check("R6 unmatched type no req", reqs(), 16'h0000);
    check("R6 unmatched stored", rd_data, 16'h1800);
    wr(16'h2800);
    check("R6 type2 no req", reqs(), 16'h0000);
  endtask

  task automatic t_no_slp();
    disk_type = 3'd5;
    wr(16'h1400);
    check("R7 no enable disk type", reqs(), 16'h0000);
    wr(16'h0000);
    check("R7 no enable type0", reqs(), 16'h0000);
    wr(16'h0400);
    check("R7 no enable type1", reqs(), 16'h0000);
  endtask

  task automatic t_back2back();
    disk_type = 3'd5;
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h2000;
    @(negedge clk); wr_data = 16'h3400;
    check("R8 first of pair", reqs(), 16'h0001);
    @(negedge clk); wr_en = 1'b0;
    check("R8 second of pair", reqs(), 16'h0004);
    @(negedge clk);
    check("R8 pair ends", reqs(), 16'h0000);
  endtask

  task automatic t_sideband();
    wr(16'h0000);
    @(negedge clk); sci_set = 1'b1;
    @(posedge clk); #1; sci_set = 1'b0;
    check("R9 set", rd_data, 16'h0001);
    @(negedge clk); sci_clr = 1'b1;
    @(posedge clk); #1; sci_clr = 1'b0;
    check("R9 clear", rd_data, 16'h0000);
    @(negedge clk); sci_set = 1'b1; sci_clr = 1'b1;
    @(posedge clk); #1; sci_set = 1'b0; sci_clr = 1'b0;
    check("R9 set wins", rd_data, 16'h0001);
  endtask

  task automatic t_overlap();
    wr(16'h0C00, 1'b1, 1'b0);
    check("R10 write with set", rd_data, 16'h0C01);
    wr(16'h0A01, 1'b0, 1'b1);
    check("R10 write with clear", rd_data, 16'h0A00);
    wr(16'h2410, 1'b1, 1'b1);
    check("R10 both with sleep", rd_data, 16'h0411);
    check("R10 request unaffected", reqs(), 16'h0002);
  endtask

  task automatic t_low_disk();
    disk_type = 3'd0;
    wr(16'h2000);
    check("R11 disk0 gives off", reqs(), 16'h0001);
    disk_type = 3'd1;
    wr(16'h2400);
    check("R11 disk1 gives ram", reqs(), 16'h0002);
    idle_cycle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_store();
    t_off();
    t_ram();
    t_disk();
    t_other();
    t_no_slp();
    t_back2back();
    t_sideband();
    t_overlap();
    t_low_disk();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule